// File: doc/BRIEF.md
# Exception State Register Unit

This block keeps the exception state of a multicycle processor core. In the same cycle that the surrounding control reports a synchronous fault (undefined opcode, arithmetic overflow, or a misaligned load or store address), or that an enabled hardware interrupt is pending, it raises a take flag and presents the fixed handler entry address as the new program counter. On the following clock edge it saves a rewound copy of the program counter and records the cause code. It also pushes a three-level kernel/enable stack so that the handler runs in kernel mode with interrupts off. For an address fault it also captures the faulting address.

Hardware interrupt requests are latched into sticky pending flags whether or not they are masked. Software clears a flag by writing a one to it. A return strobe pops the kernel/enable stack. Handler code reaches the state through a small numbered register port with a combinational read and a synchronous write.

Top module: `exc_state_unit`

## Requirements
- R1: After reset, all four registers (numbers 8, 12, 13, 14) read as zero and take_exc_o is low while no request is present.
- R2: take_exc_o is high in every cycle where undef_i, ovf_i, addr_ld_err_i or addr_st_err_i is high. redirect_pc_o equals 0x80000080 while take_exc_o is high and zero otherwise.
- R3: On the edge that ends a take cycle, register 14 (saved PC) loads pc_i minus 4 as it was in that cycle.
- R4: On a take, Cause bits [5:2] load the code of the winning source. Priority is undefined opcode (10), then overflow (12), then load address fault (4), then store address fault (5), then interrupt (0).
- R5: Status (register 12) holds the mask in bits [15:8] and three {k,e} pairs in bits [5:0]: current [1:0], previous [3:2], old [5:4], with e the lower bit of each pair. On a take, bits [5:0] become {old [3:0], 2'b00} and the mask is kept.
- R6: A return strobe without a take sets Status bits [5:0] to {old [5:4], old [5:2]}. When both occur in the same cycle, the take wins.
- R7: Cause bit 10+i (i = 0..4) is set at any edge where irq_i[i] is high, regardless of the mask or enable. It stays set until a write to register 13 carries a 1 in that bit position. A request present in the same cycle as the clear keeps the flag set.
- R8: Without a synchronous fault, take_exc_o is high exactly when some pending bit i has Status mask bit 8+i set and Status bit 0 (current enable) is 1. The recorded code is then 0.
- R9: Register 8 loads bad_addr_i only when the winning cause is a load or store address fault. Other exceptions and software writes leave it unchanged.
- R10: A write to register 12 stores bits [15:8] and [5:0], and the other bits read as zero. A write to register 14 stores all 32 bits. Writes to registers 12 and 14 are ignored in a cycle with a take or a return. Reads of any other register number return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pc_i | input | 32 | Current program counter (already advanced by 4) |
| undef_i | input | 1 | Undefined opcode detected |
| ovf_i | input | 1 | ALU arithmetic overflow |
| addr_ld_err_i | input | 1 | Address fault on load or fetch |
| addr_st_err_i | input | 1 | Address fault on store |
| bad_addr_i | input | 32 | Faulting memory address |
| irq_i | input | 5 | Hardware interrupt requests |
| eret_i | input | 1 | Return-from-exception strobe |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 5 | Register number for read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| take_exc_o | output | 1 | Exception taken this cycle |
| redirect_pc_o | output | 32 | Handler entry address while taking |

## Verification
The assertions assume that every input is settled and free of X around each rising edge. They also assume the stack pop only happens while the core runs a handler, though the properties hold for any strobe pattern. The bench changes inputs only on the falling edge. It keeps fault flags and return strobes sparse so that interrupts get a chance to fire, and it draws register numbers mostly from the mapped set so that reads cover each register often. Directed steps add the overlapping cases: two faults together, a take together with a return, a take together with a write, and a clear together with a new request.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam logic [4:0] REG_BADV   = 5'd8;
  localparam logic [4:0] REG_STATUS = 5'd12;
  localparam logic [4:0] REG_CAUSE  = 5'd13;
  localparam logic [4:0] REG_EPC    = 5'd14;

  typedef enum logic [3:0] {
    CODE_IRQ     = 4'd0,
    CODE_ADDR_LD = 4'd4,
    CODE_ADDR_ST = 4'd5,
    CODE_SYSCALL = 4'd8,
    CODE_BREAK   = 4'd9,
    CODE_RSVD    = 4'd10,
    CODE_OVF     = 4'd12
  } exc_code_e;

  typedef struct packed {
    logic undef;
    logic ovf;
    logic addr_ld;
    logic addr_st;
  } sync_req_t;
endpackage

// File: rtl/exc_prio.sv
module exc_prio
  import exc_pkg::*;
(
  input  sync_req_t req_i,
  input  logic      irq_hit_i,
  output logic      take_o,
  output logic      sync_o,
  output logic      addr_err_o,
  output exc_code_e code_o
);
  always_comb begin
    sync_o     = |req_i;
    take_o     = sync_o | irq_hit_i;
    addr_err_o = 1'b0;
    code_o     = CODE_IRQ;
    if (req_i.undef)        code_o = CODE_RSVD;
    else if (req_i.ovf)     code_o = CODE_OVF;
    else if (req_i.addr_ld) begin
      code_o     = CODE_ADDR_LD;
      addr_err_o = 1'b1;
    end else if (req_i.addr_st) begin
      code_o     = CODE_ADDR_ST;
      addr_err_o = 1'b1;
    end
  end
endmodule

// File: rtl/exc_status.sv
module exc_status #(
  parameter int unsigned STACK_DEPTH = 3,
  parameter int unsigned MASK_W      = 8,
  parameter int unsigned STATUS_W    = 16,
  localparam int unsigned LOW_W      = 2 * STACK_DEPTH,
  localparam int unsigned RSV_W      = STATUS_W - MASK_W - LOW_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                push_i,
  input  logic                pop_i,
  input  logic                we_i,
  input  logic [MASK_W-1:0]   wmask_i,
  input  logic [LOW_W-1:0]    wstack_i,
  output logic [STATUS_W-1:0] status_o,
  output logic [MASK_W-1:0]   mask_o,
  output logic                irq_en_o
);
  logic [MASK_W-1:0] mask_q;
  logic [1:0]        lvl_q [STACK_DEPTH];
  logic [LOW_W-1:0]  stack_flat;
  logic              wr_ok;

  // push and pop own the cycle; software write only when neither fires
  assign wr_ok = we_i & ~push_i & ~pop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_q <= '0;
    else if (wr_ok) mask_q <= wmask_i;
  end

  for (genvar g = 0; g < STACK_DEPTH; g++) begin : g_lvl
    logic [1:0] below, above;
    if (g == 0) begin : g_bot
      assign below = 2'b00;
    end else begin : g_mid
      assign below = lvl_q[g-1];
    end
    if (g == STACK_DEPTH - 1) begin : g_top
      assign above = lvl_q[g];
    end else begin : g_low
      assign above = lvl_q[g+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     lvl_q[g] <= 2'b00;
      else if (push_i) lvl_q[g] <= below;
      else if (pop_i)  lvl_q[g] <= above;
      else if (wr_ok)  lvl_q[g] <= wstack_i[2*g +: 2];
    end
    assign stack_flat[2*g +: 2] = lvl_q[g];
  end

  assign status_o = {mask_q, {RSV_W{1'b0}}, stack_flat};
  assign mask_o   = mask_q;
  assign irq_en_o = lvl_q[0][0];
endmodule

// File: rtl/exc_cause.sv
module exc_cause
  import exc_pkg::*;
#(
  parameter int unsigned N_IRQ = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             clr_i,
  input  logic [N_IRQ-1:0] clr_mask_i,
  input  logic             code_we_i,
  input  exc_code_e        code_i,
  output logic [N_IRQ-1:0] pend_o,
  output exc_code_e        code_o
);
  logic [N_IRQ-1:0] pend_q;
  exc_code_e        code_q;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_pend
    // a fresh request outranks a clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[g] <= 1'b0;
      else         pend_q[g] <= irq_i[g] | (pend_q[g] & ~(clr_i & clr_mask_i[g]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        code_q <= CODE_IRQ;
    else if (code_we_i) code_q <= code_i;
  end

  assign pend_o = pend_q;
  assign code_o = code_q;
endmodule

// File: rtl/exc_state_unit.sv
module exc_state_unit
  import exc_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned N_HW_IRQ    = 5,
  parameter int unsigned STACK_DEPTH = 3,
  parameter logic [31:0] EXC_VEC     = 32'h8000_0080,
  parameter int unsigned PC_STEP     = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [XLEN-1:0]     pc_i,
  input  logic                undef_i,
  input  logic                ovf_i,
  input  logic                addr_ld_err_i,
  input  logic                addr_st_err_i,
  input  logic [XLEN-1:0]     bad_addr_i,
  input  logic [N_HW_IRQ-1:0] irq_i,
  input  logic                eret_i,
  input  logic                reg_we_i,
  input  logic [4:0]          reg_addr_i,
  input  logic [XLEN-1:0]     reg_wdata_i,
  output logic [XLEN-1:0]     reg_rdata_o,
  output logic                take_exc_o,
  output logic [XLEN-1:0]     redirect_pc_o
);
  localparam int unsigned MASK_W   = 8;
  localparam int unsigned STATUS_W = 16;
  localparam int unsigned LOW_W    = 2 * STACK_DEPTH;
  localparam int unsigned PEND_LSB = 10;
  localparam int unsigned CODE_LSB = 2;
  localparam int unsigned CODE_W   = 4;

  sync_req_t             req;
  logic                  sync_hit, addr_err, irq_hit, pop;
  exc_code_e             code_sel, code_q;
  logic [STATUS_W-1:0]   status_w;
  logic [MASK_W-1:0]     mask_w;
  logic                  irq_en;
  logic [N_HW_IRQ-1:0]   pend_q;
  logic [XLEN-1:0]       epc_q, badv_q, cause_w;
  logic                  wr_status, wr_cause, wr_epc;

  assign req = '{undef: undef_i, ovf: ovf_i, addr_ld: addr_ld_err_i, addr_st: addr_st_err_i};
  assign irq_hit = (|(pend_q & mask_w[N_HW_IRQ-1:0])) & irq_en;

  exc_prio i_prio (
    .req_i      (req),
    .irq_hit_i  (irq_hit),
    .take_o     (take_exc_o),
    .sync_o     (sync_hit),
    .addr_err_o (addr_err),
    .code_o     (code_sel)
  );

  assign pop       = eret_i & ~take_exc_o;
  assign wr_status = reg_we_i && (reg_addr_i == REG_STATUS);
  assign wr_cause  = reg_we_i && (reg_addr_i == REG_CAUSE);
  assign wr_epc    = reg_we_i && (reg_addr_i == REG_EPC) && !take_exc_o && !eret_i;

  exc_status #(
    .STACK_DEPTH (STACK_DEPTH),
    .MASK_W      (MASK_W),
    .STATUS_W    (STATUS_W)
  ) i_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (take_exc_o),
    .pop_i    (pop),
    .we_i     (wr_status),
    .wmask_i  (reg_wdata_i[STATUS_W-1 -: MASK_W]),
    .wstack_i (reg_wdata_i[LOW_W-1:0]),
    .status_o (status_w),
    .mask_o   (mask_w),
    .irq_en_o (irq_en)
  );

  exc_cause #(.N_IRQ(N_HW_IRQ)) i_cause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_i      (irq_i),
    .clr_i      (wr_cause),
    .clr_mask_i (reg_wdata_i[PEND_LSB +: N_HW_IRQ]),
    .code_we_i  (take_exc_o),
    .code_i     (code_sel),
    .pend_o     (pend_q),
    .code_o     (code_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         epc_q <= '0;
    else if (take_exc_o) epc_q <= pc_i - XLEN'(PC_STEP);
    else if (wr_epc)     epc_q <= reg_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     badv_q <= '0;
    else if (take_exc_o && addr_err) badv_q <= bad_addr_i;
  end

  always_comb begin
    cause_w = '0;
    cause_w[PEND_LSB +: N_HW_IRQ] = pend_q;
    cause_w[CODE_LSB +: CODE_W]   = code_q;
  end

  always_comb begin
    unique case (reg_addr_i)
      REG_BADV:   reg_rdata_o = badv_q;
      REG_STATUS: reg_rdata_o = XLEN'(status_w);
      REG_CAUSE:  reg_rdata_o = cause_w;
      REG_EPC:    reg_rdata_o = epc_q;
      default:    reg_rdata_o = '0;
    endcase
  end

  assign redirect_pc_o = take_exc_o ? XLEN'(EXC_VEC) : '0;
endmodule

// File: rtl/exc_state_unit_chk.sv
module exc_state_unit_chk #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned N_HW_IRQ = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [XLEN-1:0]     pc_i,
  input logic                undef_i,
  input logic                ovf_i,
  input logic                addr_ld_err_i,
  input logic                addr_st_err_i,
  input logic [N_HW_IRQ-1:0] irq_i,
  input logic                eret_i,
  input logic                take_exc_o,
  input logic [XLEN-1:0]     epc_q,
  input logic [15:0]         status_w,
  input logic [N_HW_IRQ-1:0] pend_q
);
  logic sync_any;
  assign sync_any = undef_i | ovf_i | addr_ld_err_i | addr_st_err_i;

  // R2
  sync_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_any |-> take_exc_o);

  // R3
  epc_rewind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_exc_o |=> epc_q == $past(pc_i) - XLEN'(4));

  // R5
  stack_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_exc_o |=> (status_w[5:0] == {$past(status_w[3:0]), 2'b00}) &&
                   (status_w[15:8] == $past(status_w[15:8])));

  // R6
  stack_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_i && !take_exc_o) |=> status_w[5:0] == {$past(status_w[5:4]), $past(status_w[5:2])});

  // R7
  pend_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i != '0) |=> (pend_q & $past(irq_i)) == $past(irq_i));

  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_exc_o && !sync_any) |-> status_w[0] && ((pend_q & status_w[8 +: N_HW_IRQ]) != '0));
endmodule

bind exc_state_unit exc_state_unit_chk #(.XLEN(XLEN), .N_HW_IRQ(N_HW_IRQ)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pc_i          (pc_i),
  .undef_i       (undef_i),
  .ovf_i         (ovf_i),
  .addr_ld_err_i (addr_ld_err_i),
  .addr_st_err_i (addr_st_err_i),
  .irq_i         (irq_i),
  .eret_i        (eret_i),
  .take_exc_o    (take_exc_o),
  .epc_q         (epc_q),
  .status_w      (status_w),
  .pend_q        (pend_q)
);

// File: tb/test_exc_state_unit.sv
module test_exc_state_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pc_i = '0, bad_addr_i = '0, reg_wdata_i = '0;
  logic        undef_i = 0, ovf_i = 0, addr_ld_err_i = 0, addr_st_err_i = 0;
  logic [4:0]  irq_i = '0, reg_addr_i = '0;
  logic        eret_i = 0, reg_we_i = 0;
  logic [31:0] reg_rdata_o, redirect_pc_o;
  logic        take_exc_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic [15:0] m_status = '0;
  logic [4:0]  m_pend = '0;
  logic [3:0]  m_code = '0;
  logic [31:0] m_epc = '0, m_bad = '0;

  always #4 clk = ~clk;

  exc_state_unit i_exc_state_unit (
    .clk_i(clk), .rst_ni(rst_ni), .pc_i(pc_i), .undef_i(undef_i), .ovf_i(ovf_i),
    .addr_ld_err_i(addr_ld_err_i), .addr_st_err_i(addr_st_err_i), .bad_addr_i(bad_addr_i),
    .irq_i(irq_i), .eret_i(eret_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .take_exc_o(take_exc_o),
    .redirect_pc_o(redirect_pc_o)
  );

  function automatic logic f_sync();
    return undef_i | ovf_i | addr_ld_err_i | addr_st_err_i;
  endfunction

  function automatic logic f_take();
    return f_sync() | ((|(m_pend & m_status[12:8])) & m_status[0]);
  endfunction

  function automatic logic [3:0] f_code();
    if (undef_i) return 4'd10;
    if (ovf_i) return 4'd12;
    if (addr_ld_err_i) return 4'd4;
    if (addr_st_err_i) return 4'd5;
    return 4'd0;
  endfunction

  function automatic logic [31:0] f_read(logic [4:0] a);
    case (a)
      5'd8:  return m_bad;
      5'd12: return {16'b0, m_status};
      5'd13: return {16'b0, 1'b0, m_pend, 4'b0, m_code, 2'b0};
      5'd14: return m_epc;
      default: return 32'b0;
    endcase
  endfunction

  function automatic string f_tag(logic [4:0] a);
    case (a)
      5'd8:  return "R9";
      5'd12: return "R5/R6/R10";
      5'd13: return "R4/R7";
      5'd14: return "R3/R10";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic tk = f_take();
    if (tk) begin
      m_epc = pc_i - 32'd4;
      if (f_code() == 4'd4 || f_code() == 4'd5) m_bad = bad_addr_i;
      m_code = f_code();
      m_status[5:0] = {m_status[3:0], 2'b00};
    end else if (eret_i) begin
      m_status[5:0] = {m_status[5:4], m_status[5:2]};
    end else if (reg_we_i && reg_addr_i == 5'd12) begin
      m_status = {reg_wdata_i[15:8], 2'b00, reg_wdata_i[5:0]};
    end else if (reg_we_i && reg_addr_i == 5'd14) begin
      m_epc = reg_wdata_i;
    end
    m_pend = irq_i | (m_pend & ~((reg_we_i && reg_addr_i == 5'd13) ? reg_wdata_i[14:10] : 5'b0));
  endtask

  // one cycle: drive on falling edge, check before rising edge, then advance model
  task automatic step(logic [31:0] pc, logic [3:0] flt, logic [31:0] ba, logic [4:0] irq,
                      logic er, logic we, logic [4:0] a, logic [31:0] wd);
    @(negedge clk);
    pc_i = pc; {undef_i, ovf_i, addr_ld_err_i, addr_st_err_i} = flt; bad_addr_i = ba;
    irq_i = irq; eret_i = er; reg_we_i = we; reg_addr_i = a; reg_wdata_i = wd;
    #2;
    check(f_sync() ? "R2" : "R8", {31'b0, take_exc_o}, {31'b0, f_take()});
    check("R2", redirect_pc_o, f_take() ? 32'h8000_0080 : 32'h0);
    check(f_tag(a), reg_rdata_o, f_read(a));
    @(posedge clk);
    model_edge();
  endtask

  task automatic rd(logic [4:0] a);
    step(32'h100, 4'b0, 32'h0, 5'b0, 1'b0, 1'b0, a, 32'h0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    #20;
    // R1: reset values visible while reset still asserted
    for (int k = 0; k < 4; k++) begin
      logic [4:0] a = (k == 0) ? 5'd8 : (k == 1) ? 5'd12 : (k == 2) ? 5'd13 : 5'd14;
      reg_addr_i = a; #1;
      check("R1", reg_rdata_o, 32'h0);
    end
    check("R1", {31'b0, take_exc_o}, 32'h0);
    @(negedge clk); rst_ni = 1'b1;

    // R10: status write, reserved bits dropped
    step(32'h100, 4'b0, 0, 0, 0, 1, 5'd12, 32'hFFFF_1FC1);
    rd(5'd12);
    // R2/R3/R4/R5: undefined opcode
    step(32'h0000_0400, 4'b1000, 0, 0, 0, 0, 5'd12, 0);
    rd(5'd14); rd(5'd13); rd(5'd12);
    // R6: return pops back
    step(32'h100, 4'b0, 0, 0, 1, 0, 5'd12, 0);
    rd(5'd12);
    // R7: masked request still latches
    step(32'h100, 4'b0, 0, 0, 0, 1, 5'd12, 32'h0000_0001);
    step(32'h100, 4'b0, 0, 5'b00100, 0, 0, 5'd13, 0);
    rd(5'd13);
    // R8: enable the mask, interrupt taken with code 0
    step(32'h100, 4'b0, 0, 0, 0, 1, 5'd12, 32'h0000_0401);
    step(32'h0000_0804, 4'b0, 0, 0, 0, 0, 5'd13, 0);
    rd(5'd13); rd(5'd14);
    // R7: clear and new request in same cycle keeps bit; then clear
    step(32'h100, 4'b0, 0, 5'b00100, 0, 1, 5'd13, 32'h0000_7C00);
    rd(5'd13);
    step(32'h100, 4'b0, 0, 0, 0, 1, 5'd13, 32'h0000_7C00);
    rd(5'd13);
    // R9: load address fault captures, overflow keeps it
    step(32'h200, 4'b0010, 32'hDEAD_BEE1, 0, 0, 0, 5'd8, 0);
    rd(5'd8);
    step(32'h204, 4'b0100, 32'h1234_5678, 0, 0, 0, 5'd8, 0);
    rd(5'd8); rd(5'd13);
    // R4: store fault code, then undef+ovf together
    step(32'h208, 4'b0001, 32'hCAFE_0002, 0, 0, 0, 5'd13, 0);
    rd(5'd13); rd(5'd8);
    step(32'h20C, 4'b1100, 0, 0, 0, 0, 5'd13, 0);
    rd(5'd13);
    // R10: EPC write during take ignored; take wins over return
    step(32'h300, 4'b0100, 0, 0, 1, 1, 5'd14, 32'hAAAA_AAAA);
    rd(5'd14); rd(5'd12);
    step(32'h100, 4'b0, 0, 0, 0, 1, 5'd14, 32'h5555_5554);
    rd(5'd14); rd(5'd3); rd(5'd31);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [3:0]  flt = ($urandom % 12 == 0) ? 4'($urandom) : 4'b0;
      logic [4:0]  irq = ($urandom % 8 == 0) ? 5'($urandom) : 5'b0;
      logic        er  = ($urandom % 16 == 0);
      logic        we  = ($urandom % 5 == 0);
      logic [4:0]  a;
      case ($urandom % 6)
        0: a = 5'd8; 1: a = 5'd12; 2: a = 5'd13; 3: a = 5'd14; 4: a = 5'd12;
        default: a = 5'($urandom);
      endcase
      step({$urandom} & 32'hFFFF_FFFC, flt, $urandom, irq, er, we, a, $urandom);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule